// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver with Nested Service

This block chooses which of eight interrupt lines is serviced next. Pending requests that are not masked are ranked against a rotating base: the line at the base is first in priority, the line after it is second, and so on with wraparound. The block raises its request flag only when the winning request has strictly higher priority than every line already in service, so a handler can be interrupted only by something more urgent.

The block holds two pieces of state: the in-service vector and the rotation base. Decoded end-of-interrupt and priority commands, and acknowledge strobes, update that state on the clock edge. The request flag and the selected line come from combinational logic on the current inputs and state, and both are valid in the same cycle. When the block is the primary of a cascaded pair and special fully nested operation is on, the in-service bit of the cascade line is left out of the current-priority test. This lets a second request from the cascaded unit through. If a command and an acknowledge arrive in the same cycle, the command is applied and the acknowledge is dropped.

The block has no state machine. The work is done by one registered update step, which picks the next in-service vector and base with a `unique case` over the command opcode. The idle branch checks for an acknowledge instead.

Top module: `prio_resolver`

## Requirements
- R1: Priority offset of line L is (L - base) mod 8. Among unmasked pending lines, the one with the lowest offset is selected, and `line_o` gives its line number.
- R2: A line whose `mask_i` bit is 1 is never selected. With no unmasked pending line, `irq_o` is 0.
- R3: `irq_o` is 1 only when the selected offset is strictly less than the lowest offset among in-service lines. An equal or lower priority request gives `irq_o` = 0.
- R4: `ack_i` while `irq_o` = 1, with `cmd_op_i` = 0 and automatic EOI off, sets the in-service bit of `line_o` at the next edge. `ack_i` while `irq_o` = 0 changes nothing.
- R5: `cmd_op_i` = 1 (non-specific EOI) clears the in-service bit with the lowest offset. When nothing is in service, neither the in-service vector nor the base changes.
- R6: `cmd_op_i` = 2 acts as R5 and also sets the base to the cleared line plus 1, mod 8.
- R7: `cmd_op_i` = 3 clears the in-service bit of line `cmd_line_i`. `cmd_op_i` = 4 does the same and also sets the base to `cmd_line_i` plus 1, mod 8.
- R8: `cmd_op_i` = 5 sets the base to `cmd_line_i` plus 1, mod 8, and leaves the in-service vector unchanged. Opcodes 6 and 7 do nothing.
- R9: With `auto_eoi_i` = 1, an acknowledge leaves no in-service bit set. If `rot_auto_i` = 1 it also sets the base to the acknowledged line plus 1; otherwise the base is unchanged.
- R10: On the primary instance, with `nest_sfn_i` = 1, the in-service bit of line 2 (the cascade line) is ignored by the R3 test. A non-specific EOI still clears that bit.
- R11: After reset, the in-service vector is 0, the base is 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 8 | Pending request per line |
| mask_i | input | 8 | Mask per line, 1 blocks the line |
| nest_sfn_i | input | 1 | Special fully nested operation enable |
| auto_eoi_i | input | 1 | Automatic EOI on acknowledge |
| rot_auto_i | input | 1 | Rotate base on automatic EOI |
| ack_i | input | 1 | Acknowledge strobe for the selected line |
| cmd_op_i | input | 3 | Decoded command opcode (0 = none) |
| cmd_line_i | input | 3 | Line argument of the command |
| irq_o | output | 1 | Request to the processor |
| line_o | output | 3 | Selected line number |
| isr_o | output | 8 | In-service vector |
| base_o | output | 3 | Current rotation base |

## Verification
The resolver is first driven with several request vectors while the base is 0. Some of these have more than one line pending and some are partly masked, which separates lowest-offset selection from masking. Later request vectors are applied with the base at 6, 2 and 5, so that selection by rotated offset can be told apart from selection by plain line number. Nesting is tested with in-service lines set, using requests of higher, equal and lower priority; the equal case exposes any non-strict comparison. The cascade-line case is run twice, with special fully nested operation off and then on, to isolate its in-service exclusion.

// File: rtl/prio_pkg.sv
package prio_pkg;
    typedef enum logic [2:0] {
        OP_IDLE         = 3'd0,
        OP_EOI_TOP      = 3'd1,
        OP_EOI_TOP_ROT  = 3'd2,
        OP_EOI_LINE     = 3'd3,
        OP_EOI_LINE_ROT = 3'd4,
        OP_SET_BASE     = 3'd5
    } prio_op_e;
endpackage

// File: rtl/prio_scan.sv
module prio_scan #(
    parameter int N_LINES = 8,
    localparam int LW = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] vec_i,
    input  logic [LW-1:0]      base_i,
    output logic [LW:0]        off_o
);
    always_comb begin
        off_o = (LW+1)'(N_LINES);
        for (int p = N_LINES - 1; p >= 0; p--) begin
            logic [LW-1:0] idx;
            idx = LW'(p) + base_i;
            if (vec_i[idx]) off_o = (LW+1)'(p);
        end
    end
endmodule

// File: rtl/prio_state.sv
module prio_state
    import prio_pkg::*;
#(
    parameter int N_LINES = 8,
    localparam int LW = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         cmd_op_i,
    input  logic [LW-1:0]      cmd_line_i,
    input  logic               ack_fire_i,
    input  logic [LW-1:0]      ack_line_i,
    input  logic               auto_eoi_i,
    input  logic               rot_auto_i,
    input  logic               top_valid_i,
    input  logic [LW-1:0]      top_line_i,
    output logic [N_LINES-1:0] isr_q,
    output logic [LW-1:0]      base_q
);
    logic [N_LINES-1:0] isr_n;
    logic [LW-1:0]      base_n;
    prio_op_e           op;

    assign op = prio_op_e'(cmd_op_i);

    always_comb begin
        isr_n  = isr_q;
        base_n = base_q;
        unique case (op)
            OP_EOI_TOP, OP_EOI_TOP_ROT: begin
                if (top_valid_i) begin
                    isr_n[top_line_i] = 1'b0;
                    if (op == OP_EOI_TOP_ROT) base_n = top_line_i + LW'(1);
                end
            end
            OP_EOI_LINE, OP_EOI_LINE_ROT: begin
                isr_n[cmd_line_i] = 1'b0;
                if (op == OP_EOI_LINE_ROT) base_n = cmd_line_i + LW'(1);
            end
            OP_SET_BASE: base_n = cmd_line_i + LW'(1);
            OP_IDLE: begin
                if (ack_fire_i) begin
                    if (auto_eoi_i) begin
                        if (rot_auto_i) base_n = ack_line_i + LW'(1);
                    end else begin
                        isr_n[ack_line_i] = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q  <= '0;
            base_q <= '0;
        end else begin
            isr_q  <= isr_n;
            base_q <= base_n;
        end
    end

    // R5
    eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op_i == 3'd1 && isr_q == '0) |=> (isr_q == '0 && $stable(base_q)));

    // R7
    eoi_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op_i == 3'd3) |=> !isr_q[$past(cmd_line_i)]);

    // R8
    set_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op_i == 3'd5) |=> ($stable(isr_q) && (base_q - $past(cmd_line_i)) == LW'(1)));
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver #(
    parameter int N_LINES      = 8,
    parameter int CASCADE_LINE = 2,
    parameter bit IS_PRIMARY   = 1'b1,
    localparam int LW = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_i,
    input  logic [N_LINES-1:0] mask_i,
    input  logic               nest_sfn_i,
    input  logic               auto_eoi_i,
    input  logic               rot_auto_i,
    input  logic               ack_i,
    input  logic [2:0]         cmd_op_i,
    input  logic [LW-1:0]      cmd_line_i,
    output logic               irq_o,
    output logic [LW-1:0]      line_o,
    output logic [N_LINES-1:0] isr_o,
    output logic [LW-1:0]      base_o
);
    logic [N_LINES-1:0] req_eff, isr_cur, isr_q;
    logic [LW-1:0]      base_q, top_line;
    logic [LW:0]        req_off, cur_off, top_off;

    assign req_eff = req_i & ~mask_i;

    generate
        if (IS_PRIMARY) begin : g_primary
            always_comb begin
                isr_cur = isr_q;
                if (nest_sfn_i) isr_cur[CASCADE_LINE] = 1'b0;
            end
        end else begin : g_secondary
            assign isr_cur = isr_q;
        end
    endgenerate

    prio_scan #(.N_LINES(N_LINES)) u_req_scan (.vec_i(req_eff), .base_i(base_q), .off_o(req_off));
    prio_scan #(.N_LINES(N_LINES)) u_cur_scan (.vec_i(isr_cur), .base_i(base_q), .off_o(cur_off));
    prio_scan #(.N_LINES(N_LINES)) u_top_scan (.vec_i(isr_q),   .base_i(base_q), .off_o(top_off));

    assign irq_o    = (req_off < cur_off);
    assign line_o   = req_off[LW-1:0] + base_q;
    assign top_line = top_off[LW-1:0] + base_q;

    prio_state #(.N_LINES(N_LINES)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_op_i   (cmd_op_i),
        .cmd_line_i (cmd_line_i),
        .ack_fire_i (ack_i & irq_o),
        .ack_line_i (line_o),
        .auto_eoi_i (auto_eoi_i),
        .rot_auto_i (rot_auto_i),
        .top_valid_i(!top_off[LW]),
        .top_line_i (top_line),
        .isr_q      (isr_q),
        .base_q     (base_q)
    );

    assign isr_o  = isr_q;
    assign base_o = base_q;

    // R2
    sel_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (req_i[line_o] && !mask_i[line_o]));

    // R4
    ack_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && !auto_eoi_i && cmd_op_i == 3'd0) |=> isr_o[$past(line_o)]);

    // R9
    auto_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && auto_eoi_i && cmd_op_i == 3'd0) |=> $stable(isr_o));
endmodule

// File: tb/tb_prio_resolver.sv
module tb_prio_resolver;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic [7:0] req = '0, mask = '0;
    logic       sfn = 1'b0, aeoi = 1'b0, rota = 1'b0, ack = 1'b0;
    logic [2:0] op = '0, cline = '0;
    logic       irq;
    logic [2:0] line, base;
    logic [7:0] isr;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    prio_resolver dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(mask), .nest_sfn_i(sfn),
        .auto_eoi_i(aeoi), .rot_auto_i(rota), .ack_i(ack), .cmd_op_i(op),
        .cmd_line_i(cline), .irq_o(irq), .line_o(line), .isr_o(isr), .base_o(base));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic settle(input logic [7:0] r, input logic [7:0] m);
        req = r; mask = m; #1;
    endtask

    task automatic do_ack();
        ack = 1'b1; @(negedge clk); ack = 1'b0; #1;
    endtask

    task automatic do_op(input logic [2:0] o, input logic [2:0] l);
        op = o; cline = l; @(negedge clk); op = '0; cline = '0; #1;
    endtask

    task automatic t_reset();
        chk("R11 irq", irq, 0); chk("R11 isr", isr, 0); chk("R11 base", base, 0);
    endtask

    task automatic t_basic();
        settle(8'hA4, 8'h00); chk("R1 irq", irq, 1); chk("R1 line", line, 2);
        settle(8'hA0, 8'h00); chk("R1 line", line, 5);
    endtask

    task automatic t_mask();
        settle(8'hA4, 8'h04); chk("R2 line", line, 5);
        settle(8'hA4, 8'hA4); chk("R2 irq", irq, 0);
    endtask

    task automatic t_nest();
        settle(8'h24, 8'h04); do_ack(); chk("R4 isr", isr, 8'h20);
        chk("R3 equal", irq, 0);
        settle(8'h80, 8'h00); chk("R3 lower", irq, 0);
        settle(8'h08, 8'h00); chk("R3 higher", irq, 1); chk("R3 line", line, 3);
        do_ack(); chk("R4 isr2", isr, 8'h28);
        settle(8'h80, 8'h00); do_ack(); chk("R4 noack", isr, 8'h28);
    endtask

    task automatic t_ns_eoi();
        do_op(3'd1, 3'd0); chk("R5 isr", isr, 8'h20); chk("R5 base", base, 0);
        do_op(3'd2, 3'd0); chk("R6 isr", isr, 0); chk("R6 base", base, 6);
        settle(8'h21, 8'h00); chk("R1 rot line", line, 0);
        settle(8'h60, 8'h00); chk("R1 rot line6", line, 6);
    endtask

    task automatic t_set_base();
        settle(8'h04, 8'h00); chk("R1 line2", line, 2); do_ack();
        do_op(3'd5, 3'd1); chk("R8 base", base, 2); chk("R8 isr", isr, 8'h04);
        do_op(3'd6, 3'd3); chk("R8 nop base", base, 2); chk("R8 nop isr", isr, 8'h04);
        settle(8'h08, 8'h00); chk("R3 rot lower", irq, 0);
        do_op(3'd3, 3'd2); chk("R7 isr", isr, 0); chk("R7 irq", irq, 1);
    endtask

    task automatic t_spec_rot();
        settle(8'h10, 8'h00); chk("R1 line4", line, 4); do_ack();
        do_op(3'd4, 3'd4); chk("R7 rot isr", isr, 0); chk("R7 rot base", base, 5);
        do_op(3'd1, 3'd0); chk("R5 empty isr", isr, 0); chk("R5 empty base", base, 5);
    endtask

    task automatic t_auto();
        aeoi = 1'b1; rota = 1'b1;
        settle(8'h02, 8'h00); chk("R9 line", line, 1); do_ack();
        chk("R9 isr", isr, 0); chk("R9 base", base, 2);
        rota = 1'b0; settle(8'h40, 8'h00); do_ack();
        chk("R9 norot isr", isr, 0); chk("R9 norot base", base, 2);
        aeoi = 1'b0;
    endtask

    task automatic t_sfn();
        settle(8'h04, 8'h00); do_ack(); chk("R10 isr", isr, 8'h04);
        chk("R10 off", irq, 0);
        sfn = 1'b1; #1; chk("R10 on irq", irq, 1); chk("R10 on line", line, 2);
        do_op(3'd1, 3'd0); chk("R10 eoi", isr, 0);
        sfn = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1; #1;
        t_reset(); t_basic(); t_mask(); t_nest(); t_ns_eoi();
        t_set_base(); t_spec_rot(); t_auto(); t_sfn();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule